// File: doc/BRIEF.md
# Receive Descriptor and Status Queue Engine

The engine takes a received frame as a stream of bytes, one per clock, and writes it into a memory buffer. The buffer comes from a circular descriptor ring. For each stored frame it then writes a two-word status entry into a second circular ring. Software returns ring entries by writing a count to one of two enqueue registers. Each count is added to that ring's available-entry credit. A posted status entry raises a receive interrupt bit, and software clears that bit by reading it.

The engine fetches the next descriptor ahead of time, while the byte stream is idle. The first byte of a frame can then go straight to memory. All traffic uses one simple memory port. A read request returns data in the next cycle, and the port accepts every request. A frame that finds no descriptor held, or no status credit, is dropped. The overrun is then reported in the next status entry that is written.

The byte source must leave at least 8 idle cycles between frames, and after a credit write, before the next frame starts.

Top module: `rx_queue_engine`

## Requirements
- R1: When the engine holds no descriptor and the descriptor credit is non-zero, it reads two words from the descriptor current pointer and takes one credit. Word 0 is the buffer address. Bits 30:16 of word 1 are the buffer index.
- R2: Frame bytes are packed little-endian into 32-bit words. Byte n goes to buffer address + n. Bytes at offset MAX_LEN and above are not written.
- R3: A stored frame gets a status word 1 at status current pointer + 4: bit 31 = 1, bits 30:16 = buffer index, bits 15:0 = received byte count. Word 1 is written before word 0.
- R4: Status word 0 is written at the status current pointer with these bits:
  - bits 31, 29 and 28 are 1.
  - bit 18 is set when the length is below MIN_LEN.
  - bit 17 is set when the length is above MAX_LEN.
  - bits 16 and 19 are the OR of the CRC-error and framing-error inputs over the frame.
  - bit 20 is the pending overrun.
  - bit 21 is set if any of bits 20:16 is set, and bit 30 is set if none is.
  - bit 15 equals CRC_INCLUDED.
  - all other bits are 0.
- R5: Each ring pointer moves by 8 bytes per entry and returns to the ring base when it reaches base + length. Writing a ring base also sets that ring's current pointer.
- R6: Register offsets on reg_addr:
  - 0: descriptor ring base; 1: descriptor ring length in bytes.
  - 2: status ring base; 3: status ring length in bytes.
  - 4 and 5: writing N adds N to the descriptor or status credit.
  - 7 and 8: read back the descriptor and status credit.
- R7: A frame that starts with no descriptor held, or with zero status credit, is dropped. It causes no memory write, no status entry and no interrupt. The next status entry written has bit 20 set.
- R8: Posting a status entry sets bit 2 of register 6, and irq follows that bit. Reading register 6 returns the bit and clears it.
- R9: After reset the engine makes no memory request, irq is low and both credits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears interrupt status on offset 6) |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| rx_valid | input | 1 | Byte valid |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Last byte of frame |
| rx_crc_err | input | 1 | CRC error flag |
| rx_frame_err | input | 1 | Framing error flag |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after a read request |
| irq | output | 1 | Receive interrupt |

## Verification
The bench builds the engine with 64-byte buffers, MAX_LEN 60 and MIN_LEN 8. It programs 8-entry rings. With these values, frames of 1 to 72 bytes cover runt, exact-maximum and excess lengths within a few dozen cycles each. Several laps of both rings give repeated pointer wrap. Draining the credits brings both drop causes within reach: a missing descriptor, and a held descriptor with zero status credit. The overrun bit is then checked on the next entry.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH0, ST_FETCH1, ST_FETCH2,
    ST_RECV, ST_DROP, ST_STAT1, ST_STAT0
  } rxq_state_e;

  localparam int unsigned ENTRY_BYTES = 8;

  localparam logic [3:0] RA_DBASE = 4'd0;
  localparam logic [3:0] RA_DLEN  = 4'd1;
  localparam logic [3:0] RA_SBASE = 4'd2;
  localparam logic [3:0] RA_SLEN  = 4'd3;
  localparam logic [3:0] RA_DENQ  = 4'd4;
  localparam logic [3:0] RA_SENQ  = 4'd5;
  localparam logic [3:0] RA_INT   = 4'd6;
  localparam logic [3:0] RA_DCRED = 4'd7;
  localparam logic [3:0] RA_SCRED = 4'd8;

  localparam int unsigned B_PROC  = 31;
  localparam int unsigned B_OK    = 30;
  localparam int unsigned B_EOF   = 29;
  localparam int unsigned B_EOB   = 28;
  localparam int unsigned B_ERR   = 21;
  localparam int unsigned B_OVR   = 20;
  localparam int unsigned B_FE    = 19;
  localparam int unsigned B_RUNT  = 18;
  localparam int unsigned B_EXC   = 17;
  localparam int unsigned B_CRC   = 16;
  localparam int unsigned B_CRCI  = 15;
  localparam int unsigned INT_BIT = 2;
endpackage

// File: rtl/rxq_ring.sv
module rxq_ring #(
  parameter int AW   = 32,
  parameter int CW   = 16,
  parameter int STEP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_we,
  input  logic [AW-1:0] base_in,
  input  logic          len_we,
  input  logic [AW-1:0] len_in,
  input  logic          enq_we,
  input  logic [CW-1:0] enq_in,
  input  logic          advance,
  output logic [AW-1:0] cur,
  output logic [CW-1:0] credit
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  logic [AW-1:0] base_q, base_d, len_q, len_d, cur_q, cur_d, nxt;
  logic [CW-1:0] cred_q, cred_d;

  always_comb begin
    base_d = base_we ? base_in : base_q;
    len_d  = len_we ? len_in : len_q;
    nxt    = cur_q + STEP_V;
    cur_d  = cur_q;
    if (base_we)      cur_d = base_in;
    else if (advance) cur_d = (nxt == base_q + len_q) ? base_q : nxt;
    cred_d = cred_q + (enq_we ? enq_in : '0) - (advance ? CW'(1) : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
      cur_q  <= '0;
      cred_q <= '0;
    end else begin
      base_q <= base_d;
      len_q  <= len_d;
      cur_q  <= cur_d;
      cred_q <= cred_d;
    end
  end

  assign cur    = cur_q;
  assign credit = cred_q;

  // R1: an entry is only consumed against available credit
  p_no_underflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> cred_q != '0);
endmodule

// File: rtl/rxq_pack.sv
module rxq_pack #(
  parameter int LW    = 16,
  parameter int LIMIT = 2044
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld,
  input  logic          first,
  input  logic          last,
  input  logic          store,
  input  logic [7:0]    data,
  output logic          wr_en,
  output logic [LW-1:0] wr_off,
  output logic [31:0]   wr_word,
  output logic [LW-1:0] pos
);
  logic [LW-1:0] cnt_q, cnt_d;
  logic [31:0]   acc_q, acc_d, merged;

  always_comb begin
    pos    = first ? '0 : cnt_q;
    merged = (pos[1:0] == 2'd0) ? 32'd0 : acc_q;
    merged[8*pos[1:0] +: 8] = data;
    wr_en   = vld && store && (pos < LW'(LIMIT)) && ((pos[1:0] == 2'd3) || last);
    wr_off  = {pos[LW-1:2], 2'b00};
    wr_word = merged;
    cnt_d   = vld ? pos + LW'(1) : cnt_q;
    acc_d   = vld ? merged : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
    end
  end
endmodule

// File: rtl/rx_queue_engine.sv
module rx_queue_engine
  import rxq_pkg::*;
#(
  parameter int AW           = 32,
  parameter int CW           = 16,
  parameter int LW           = 16,
  parameter int BUF_BYTES    = 2048,
  parameter int MAX_LEN      = 2044,
  parameter int MIN_LEN      = 64,
  parameter bit CRC_INCLUDED = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  input  logic          rx_crc_err,
  input  logic          rx_frame_err,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          irq
);
  localparam int STORE_LIM = (MAX_LEN < BUF_BYTES) ? MAX_LEN : BUF_BYTES;

  rxq_state_e    st_q, st_d;
  logic          have_q, have_d, crc_q, crc_d, fe_q, fe_d, ovr_q, ovr_d, int_q, int_d;
  logic [AW-1:0] bufa_q, bufa_d;
  logic [14:0]   idx_q, idx_d;
  logic [LW-1:0] len_q, len_d;

  logic [AW-1:0] d_cur, s_cur;
  logic [CW-1:0] d_cred, s_cred;
  logic          d_adv, s_adv;

  logic          first, accept, pk_vld, pk_store, pk_wr;
  logic [LW-1:0] pk_off, pk_pos;
  logic [31:0]   pk_word;

  logic          f_req, f_we;
  logic [AW-1:0] f_addr;
  logic [31:0]   f_wdata, w0, w1;
  logic          runt, excess, bad, int_rd;

  // ---------------- rings ----------------
  rxq_ring #(.AW(AW), .CW(CW), .STEP(ENTRY_BYTES)) u_dring (
    .clk(clk), .rst_n(rst_n),
    .base_we(reg_wr && reg_addr == RA_DBASE), .base_in(reg_wdata[AW-1:0]),
    .len_we(reg_wr && reg_addr == RA_DLEN), .len_in(reg_wdata[AW-1:0]),
    .enq_we(reg_wr && reg_addr == RA_DENQ), .enq_in(reg_wdata[CW-1:0]),
    .advance(d_adv), .cur(d_cur), .credit(d_cred));

  rxq_ring #(.AW(AW), .CW(CW), .STEP(ENTRY_BYTES)) u_sring (
    .clk(clk), .rst_n(rst_n),
    .base_we(reg_wr && reg_addr == RA_SBASE), .base_in(reg_wdata[AW-1:0]),
    .len_we(reg_wr && reg_addr == RA_SLEN), .len_in(reg_wdata[AW-1:0]),
    .enq_we(reg_wr && reg_addr == RA_SENQ), .enq_in(reg_wdata[CW-1:0]),
    .advance(s_adv), .cur(s_cur), .credit(s_cred));

  // ---------------- byte packing ----------------
  assign first    = rx_valid && (st_q == ST_IDLE);
  assign accept   = have_q && (s_cred != '0);
  assign pk_vld   = rx_valid && (st_q == ST_IDLE || st_q == ST_RECV || st_q == ST_DROP);
  assign pk_store = (st_q == ST_RECV) || (st_q == ST_IDLE && accept);

  rxq_pack #(.LW(LW), .LIMIT(STORE_LIM)) u_pack (
    .clk(clk), .rst_n(rst_n), .vld(pk_vld), .first(first), .last(rx_last),
    .store(pk_store), .data(rx_data), .wr_en(pk_wr), .wr_off(pk_off),
    .wr_word(pk_word), .pos(pk_pos));

  // ---------------- status words ----------------
  always_comb begin
    runt   = len_q < LW'(MIN_LEN);
    excess = len_q > LW'(MAX_LEN);
    bad    = ovr_q | fe_q | crc_q | runt | excess;
    w0 = '0;
    w0[B_PROC] = 1'b1;
    w0[B_OK]   = !bad;
    w0[B_EOF]  = 1'b1;
    w0[B_EOB]  = 1'b1;
    w0[B_ERR]  = bad;
    w0[B_OVR]  = ovr_q;
    w0[B_FE]   = fe_q;
    w0[B_RUNT] = runt;
    w0[B_EXC]  = excess;
    w0[B_CRC]  = crc_q;
    w0[B_CRCI] = CRC_INCLUDED;
    w1 = '0;
    w1[31]    = 1'b1;
    w1[30:16] = idx_q;
    w1[15:0]  = 16'(len_q);
  end

  // ---------------- control next state ----------------
  assign int_rd = reg_rd && reg_addr == RA_INT;

  always_comb begin
    st_d = st_q; have_d = have_q; bufa_d = bufa_q; idx_d = idx_q;
    len_d = len_q; crc_d = crc_q; fe_d = fe_q; ovr_d = ovr_q;
    int_d = int_rd ? 1'b0 : int_q;
    d_adv = 1'b0; s_adv = 1'b0;
    f_req = 1'b0; f_we = 1'b0; f_addr = '0; f_wdata = '0;
    if (pk_vld) begin
      len_d = pk_pos + LW'(1);
      crc_d = (first ? 1'b0 : crc_q) | rx_crc_err;
      fe_d  = (first ? 1'b0 : fe_q) | rx_frame_err;
    end
    case (st_q)
      ST_IDLE: begin
        if (rx_valid) begin
          if (accept) st_d = rx_last ? ST_STAT1 : ST_RECV;
          else begin
            ovr_d = 1'b1;
            st_d  = rx_last ? ST_IDLE : ST_DROP;
          end
        end else if (!have_q && d_cred != '0) begin
          st_d = ST_FETCH0;
        end
      end
      ST_FETCH0: begin
        f_req  = 1'b1;
        f_addr = d_cur;
        st_d   = ST_FETCH1;
      end
      ST_FETCH1: begin
        f_req  = 1'b1;
        f_addr = d_cur + AW'(4);
        bufa_d = mem_rdata[AW-1:0];
        st_d   = ST_FETCH2;
      end
      ST_FETCH2: begin
        idx_d  = mem_rdata[30:16];
        have_d = 1'b1;
        d_adv  = 1'b1;
        st_d   = ST_IDLE;
      end
      ST_RECV: if (rx_valid && rx_last) st_d = ST_STAT1;
      ST_DROP: if (rx_valid && rx_last) st_d = ST_IDLE;
      ST_STAT1: begin
        f_req = 1'b1; f_we = 1'b1;
        f_addr = s_cur + AW'(4); f_wdata = w1;
        st_d = ST_STAT0;
      end
      ST_STAT0: begin
        f_req = 1'b1; f_we = 1'b1;
        f_addr = s_cur; f_wdata = w0;
        s_adv = 1'b1; have_d = 1'b0; ovr_d = 1'b0; int_d = 1'b1;
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; have_q <= 1'b0; bufa_q <= '0; idx_q <= '0;
      len_q <= '0; crc_q <= 1'b0; fe_q <= 1'b0; ovr_q <= 1'b0; int_q <= 1'b0;
    end else begin
      st_q <= st_d; have_q <= have_d; bufa_q <= bufa_d; idx_q <= idx_d;
      len_q <= len_d; crc_q <= crc_d; fe_q <= fe_d; ovr_q <= ovr_d; int_q <= int_d;
    end
  end

  // ---------------- outputs ----------------
  assign mem_req   = pk_wr | f_req;
  assign mem_we    = pk_wr | f_we;
  assign mem_addr  = pk_wr ? bufa_q + AW'(pk_off) : f_addr;
  assign mem_wdata = pk_wr ? pk_word : f_wdata;
  assign irq       = int_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_INT:   reg_rdata[INT_BIT] = int_q;
      RA_DCRED: reg_rdata = 32'(d_cred);
      RA_SCRED: reg_rdata = 32'(s_cred);
      default:  reg_rdata = '0;
    endcase
  end

  // ---------------- assertions ----------------
  // R2: buffer stores never collide with descriptor or status traffic
  p_one_user_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(pk_wr && f_req));
  // R3: word 0 of a status entry always follows word 1 of the same entry
  p_w1_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !pk_wr && mem_addr == s_cur) |->
      $past(mem_we && mem_addr == s_cur + AW'(4)));
  // R7: a dropped frame touches no memory
  p_drop_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DROP) |-> !mem_we);
  // R8: interrupt rises only after a status word 0 was posted
  p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(st_q == ST_STAT0));
  // R8: read of the interrupt register clears it
  p_rdclr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (int_rd && st_q != ST_STAT0) |=> !irq);
endmodule

// File: tb/rx_queue_engine_bench.sv
module rx_queue_engine_bench;
  localparam int BUFB = 64;
  localparam int MAXL = 60;
  localparam int MINL = 8;
  localparam int NENT = 8;
  localparam int SBASE = 32'h100;
  localparam int BBASE = 32'h1000;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_wr, reg_rd;
  logic [3:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic rx_valid, rx_last, rx_crc_err, rx_frame_err;
  logic [7:0] rx_data;
  logic mem_req, mem_we, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  logic [31:0] mem [0:2047];
  logic [7:0] fb [0:127];
  int checks = 0, errors = 0, slot = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rx_queue_engine #(.BUF_BYTES(BUFB), .MAX_LEN(MAXL), .MIN_LEN(MINL)) u_rx_queue_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .rx_crc_err(rx_crc_err), .rx_frame_err(rx_frame_err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .irq(irq));

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[12:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[12:2]];
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  function automatic logic [31:0] exp_w0(int len, bit crc, bit fe, bit ovr);
    logic [31:0] w = '0;
    bit runt = len < MINL, exc = len > MAXL;
    bit bad = crc | fe | ovr | runt | exc;
    w[31] = 1; w[30] = !bad; w[29] = 1; w[28] = 1; w[21] = bad; w[20] = ovr;
    w[19] = fe; w[18] = runt; w[17] = exc; w[16] = crc; w[15] = 1;
    return w;
  endfunction

  task automatic send(int len, bit crc, bit fe);
    for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = fb[i]; rx_last = (i == len - 1);
      rx_crc_err = crc && (i == len - 1); rx_frame_err = fe && (i == len - 1);
    end
    @(negedge clk); rx_valid = 0; rx_last = 0; rx_crc_err = 0; rx_frame_err = 0;
    repeat (10) @(negedge clk);
  endtask

  task automatic check_frame(int len, bit crc, bit fe, bit ovr);
    int sw = (SBASE >> 2) + slot * 2;
    int bad = 0;
    logic [31:0] e1, r;
    e1 = {1'b1, 15'(slot), 16'(len)};
    chk(mem[sw + 1] == e1, "R3 status word1", mem[sw + 1], e1);
    chk(mem[sw] == exp_w0(len, crc, fe, ovr), "R4 status word0", mem[sw], exp_w0(len, crc, fe, ovr));
    for (int b = 0; b < len && b < MAXL; b++) begin
      logic [31:0] wd = mem[(BBASE + slot * BUFB + b) >> 2];
      if (wd[8*(b%4) +: 8] != fb[b]) bad++;
    end
    chk(bad == 0, "R2 buffer bytes", 32'(bad), 0);
    chk(irq == 1'b1, "R8 irq raised", {31'b0, irq}, 1);
    rd(4'd6, r);
    chk(r == 32'd4, "R8 int status read", r, 4);
    chk(irq == 1'b0, "R8 irq cleared by read", {31'b0, irq}, 0);
    mem[sw] = 0; mem[sw + 1] = 0;
    slot = (slot + 1) % NENT;
  endtask

  task automatic check_drop(int len);
    int sw = (SBASE >> 2) + slot * 2;
    send(len, 0, 0);
    chk(irq == 1'b0, "R7 no irq on drop", {31'b0, irq}, 0);
    chk(mem[sw] == 0 && mem[sw + 1] == 0, "R7 no status on drop", mem[sw + 1], 0);
  endtask

  initial begin
    logic [31:0] r;
    void'($urandom(32'd2024));
    rst_n = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    rx_valid = 0; rx_data = 0; rx_last = 0; rx_crc_err = 0; rx_frame_err = 0;
    for (int i = 0; i < 2048; i++) mem[i] = 0;
    for (int i = 0; i < NENT; i++) begin
      mem[2 * i] = BBASE + i * BUFB;
      mem[2 * i + 1] = (i << 16) | BUFB;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(irq == 0 && mem_req == 0, "R9 reset outputs", {30'b0, irq, mem_req}, 0);
    rd(4'd7, r); chk(r == 0, "R9 descriptor credit after reset", r, 0);
    rd(4'd8, r); chk(r == 0, "R9 status credit after reset", r, 0);

    wr(4'd0, 0); wr(4'd1, NENT * 8); wr(4'd2, SBASE); wr(4'd3, NENT * 8);
    wr(4'd4, 5); wr(4'd4, 3); wr(4'd5, NENT);
    repeat (8) @(negedge clk);
    rd(4'd7, r); chk(r == 7, "R6 R1 descriptor credit added and one fetched", r, 7);
    rd(4'd8, r); chk(r == 8, "R6 status credit added", r, 8);

    // directed lengths: runt, minimum, exact maximum, excess; then random (R5 wrap)
    for (int f = 0; f < 22; f++) begin
      int len; bit crc, fe;
      case (f)
        0: len = 1;  1: len = MINL;  2: len = MAXL;  3: len = MAXL + 1;
        default: len = 1 + int'($urandom % 72);
      endcase
      crc = (f > 3) && ($urandom % 4 == 0);
      fe  = (f > 3) && ($urandom % 4 == 0);
      send(len, crc, fe);
      check_frame(len, crc, fe, 0);
      wr(4'd4, 1); wr(4'd5, 1);
      repeat (6) @(negedge clk);
    end

    // drain all credits
    for (int f = 0; f < NENT; f++) begin
      int len = 4 + int'($urandom % 50);
      send(len, 0, 0);
      check_frame(len, 0, 0, 0);
    end
    check_drop(20);                      // R7 no descriptor
    wr(4'd4, 1); repeat (6) @(negedge clk);
    check_drop(12);                      // R7 descriptor held, no status credit
    wr(4'd5, 1); repeat (6) @(negedge clk);
    send(30, 0, 0); check_frame(30, 0, 0, 1);   // R7 overrun reported
    wr(4'd4, 1); wr(4'd5, 1); repeat (6) @(negedge clk);
    send(17, 0, 0); check_frame(17, 0, 0, 0);   // R7 overrun cleared after posting

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule